// File: doc/BRIEF.md
# Data-Side Translation Buffer with Page-Table Walker

This block turns virtual data addresses into physical ones for a data cache. It keeps a small fully associative set of page translations. Each entry pairs a virtual page number with a physical frame number. A request whose page is present is answered in the next cycle. The physical address is the stored frame joined to the untranslated page offset.

A request whose page is absent starts a walk. The walker forms the address of the page-table entry from a base input and the page number. It issues one read on a miss-handling memory port with a valid/ready request handshake, then waits for the returning entry. It writes the frame into the buffer and answers the original request. Only one walk runs at a time. While it runs, `busy_o` is high and incoming requests are dropped, so the requester must hold off and retry. A thread tag travels with each request but plays no part in matching.

Top module: `dtlb_walker`

## Requirements
- R1: The page offset is the low OFF_W = log2(PAGE_BYTES) bits of `req_vaddr_i` (12 bits at the default 4096-byte page), and the virtual page number is the remaining upper bits. Only the page number is looked up. The offset passes through unchanged as the low OFF_W bits of `resp_paddr_o`.
- R2: A request is accepted at a rising edge where `req_valid_i` is high and `busy_o` is low. If its page is held, `resp_valid_o` is high in the next cycle with `resp_hit_o` = 1 and `resp_paddr_o` = {stored frame, offset}.
- R3: If an accepted request misses, `busy_o` and `mem_req_valid_o` are high from the next cycle. `mem_req_addr_o` = `pt_base_i` + page number × PTE_BYTES (4 by default). Request and address hold until an edge where `mem_req_ready_i` is high, after which `mem_req_valid_o` is low.
- R4: After the handshake the walker waits for `mem_resp_valid_i`. The frame is `mem_resp_pte_i[PFN_W-1:0]`; the upper bits are ignored. In the next cycle `busy_o` is low and `resp_valid_o` is high with `resp_hit_o` = 0 and `resp_paddr_o` = {frame, offset}.
- R5: A walked translation is installed, so a later request to the same page hits with that frame.
- R6: An install takes the lowest-numbered invalid entry. If every entry is valid, it replaces the least recently used one, where both hits and installs count as uses.
- R7: While `busy_o` is high, `req_valid_i` is ignored: it gives no response and changes neither the buffer contents nor the use order.
- R8: `req_tid_i` has no effect on matching, replacement or the response.
- R9: `mem_resp_valid_i` is ignored unless the walker is waiting for a page-table entry.
- R10: Reset clears every entry to invalid and drives `busy_o`, `resp_valid_o` and `mem_req_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | VA_W | Virtual address |
| req_tid_i | input | TID_W | Thread tag, not used for matching |
| busy_o | output | 1 | Walk in progress, requests dropped |
| resp_valid_o | output | 1 | Translation result valid |
| resp_hit_o | output | 1 | Result came from a stored entry |
| resp_paddr_o | output | PA_W | Physical address |
| pt_base_i | input | PA_W | Page-table base address |
| mem_req_valid_o | output | 1 | Page-table entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | PA_W | Page-table entry address |
| mem_resp_valid_i | input | 1 | Page-table entry returned |
| mem_resp_pte_i | input | PTE_W | Returned entry, frame in the low bits |

## Verification
A stale or wrongly chosen entry does not fail at once. It shows up the next time its page is requested: `resp_hit_o` has the wrong sense, or `resp_paddr_o` carries another page's frame, one cycle after acceptance. A corrupted use order stays hidden until the buffer is full. It then becomes visible as a miss where a hit was due, some requests later. That is why the bench compares every cycle against a reference that keeps its own recency list, and drives many more pages than entries. A walker stuck in the wrong state is seen on `busy_o` and `mem_req_valid_o` within a cycle.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE,
    WALK_REQ,
    WALK_WAIT
  } walk_state_e;
endpackage

// File: rtl/dtlb_array.sv
module dtlb_array #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] look_vpn_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output logic [PFN_W-1:0] hit_pfn_o,
  output logic             free_o,
  output logic [IDX_W-1:0] free_idx_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PFN_W-1:0] wr_pfn_i
);
  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] match;
  logic [PFN_W-1:0]   frm [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             v_q;
    logic [VPN_W-1:0] t_q;
    logic [PFN_W-1:0] f_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        t_q <= '0;
        f_q <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        v_q <= 1'b1;
        t_q <= wr_vpn_i;
        f_q <= wr_pfn_i;
      end
    end

    assign vld[g]   = v_q;
    assign frm[g]   = f_q;
    assign match[g] = v_q && (t_q == look_vpn_i);
  end

  assign hit_o = |match;

  // tags are unique, so OR-reduction acts as a mux
  always_comb begin
    hit_idx_o = '0;
    hit_pfn_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_idx_o = hit_idx_o | IDX_W'(i);
        hit_pfn_o = hit_pfn_o | frm[i];
      end
    end
  end

  // lowest-numbered invalid slot wins
  always_comb begin
    free_o     = 1'b0;
    free_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_o     = 1'b1;
        free_idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dtlb_lru.sv
module dtlb_lru #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] lru_idx_o
);
  // ages form a permutation of 0..ENTRIES-1; 0 is most recent
  logic [IDX_W-1:0] age [ENTRIES];
  logic [IDX_W-1:0] ref_age;

  assign ref_age = age[touch_idx_i];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age[g] <= IDX_W'(g);
      end else if (touch_i) begin
        if (touch_idx_i == IDX_W'(g)) age[g] <= '0;
        else if (age[g] < ref_age)    age[g] <= age[g] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (age[i] == IDX_W'(ENTRIES - 1)) lru_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dtlb_walker.sv
module dtlb_walker
  import dtlb_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int ENTRIES    = 8,
  parameter int PTE_BYTES  = 4,
  parameter int PTE_W      = 32,
  parameter int TID_W      = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [VA_W-1:0] req_vaddr_i,
  input  logic [TID_W-1:0] req_tid_i,
  output logic            busy_o,
  output logic            resp_valid_o,
  output logic            resp_hit_o,
  output logic [PA_W-1:0] resp_paddr_o,
  input  logic [PA_W-1:0] pt_base_i,
  output logic            mem_req_valid_o,
  input  logic            mem_req_ready_i,
  output logic [PA_W-1:0] mem_req_addr_o,
  input  logic            mem_resp_valid_i,
  input  logic [PTE_W-1:0] mem_resp_pte_i
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PFN_W  = PA_W - OFF_W;
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int PTE_SH = $clog2(PTE_BYTES);

  walk_state_e      st_q;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic             resp_valid_q, resp_hit_q;
  logic [PA_W-1:0]  resp_paddr_q;

  logic [VPN_W-1:0] look_vpn;
  logic [OFF_W-1:0] look_off;
  logic             hit, free;
  logic [IDX_W-1:0] hit_idx, free_idx, lru_idx, victim;
  logic [PFN_W-1:0] hit_pfn, new_pfn;
  logic             accept, fill, touch;
  logic [IDX_W-1:0] touch_idx;

  assign look_vpn = req_vaddr_i[VA_W-1:OFF_W];
  assign look_off = req_vaddr_i[OFF_W-1:0];
  assign accept   = req_valid_i && (st_q == WALK_IDLE);
  assign fill     = (st_q == WALK_WAIT) && mem_resp_valid_i;
  assign new_pfn  = mem_resp_pte_i[PFN_W-1:0];
  assign victim   = free ? free_idx : lru_idx;
  assign touch    = (accept && hit) || fill;
  assign touch_idx = fill ? victim : hit_idx;

  dtlb_array #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W)
  ) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .look_vpn_i (look_vpn),
    .hit_o      (hit),
    .hit_idx_o  (hit_idx),
    .hit_pfn_o  (hit_pfn),
    .free_o     (free),
    .free_idx_o (free_idx),
    .wr_en_i    (fill),
    .wr_idx_i   (victim),
    .wr_vpn_i   (vpn_q),
    .wr_pfn_i   (new_pfn)
  );

  dtlb_lru #(
    .ENTRIES (ENTRIES)
  ) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch),
    .touch_idx_i (touch_idx),
    .lru_idx_o   (lru_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= WALK_IDLE;
      vpn_q        <= '0;
      off_q        <= '0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_paddr_q <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      unique case (st_q)
        WALK_IDLE: begin
          if (accept) begin
            if (hit) begin
              resp_valid_q <= 1'b1;
              resp_hit_q   <= 1'b1;
              resp_paddr_q <= {hit_pfn, look_off};
            end else begin
              st_q  <= WALK_REQ;
              vpn_q <= look_vpn;
              off_q <= look_off;
            end
          end
        end
        WALK_REQ: begin
          if (mem_req_ready_i) st_q <= WALK_WAIT;
        end
        WALK_WAIT: begin
          if (mem_resp_valid_i) begin
            st_q         <= WALK_IDLE;
            resp_valid_q <= 1'b1;
            resp_hit_q   <= 1'b0;
            resp_paddr_q <= {new_pfn, off_q};
          end
        end
        default: st_q <= WALK_IDLE;
      endcase
    end
  end

  assign busy_o          = (st_q != WALK_IDLE);
  assign mem_req_valid_o = (st_q == WALK_REQ);
  assign mem_req_addr_o  = pt_base_i + (PA_W'(vpn_q) << PTE_SH);
  assign resp_valid_o    = resp_valid_q;
  assign resp_hit_o      = resp_hit_q;
  assign resp_paddr_o    = resp_paddr_q;

  logic unused_bits;
  assign unused_bits = ^{req_tid_i, mem_resp_pte_i[PTE_W-1:PFN_W]};
endmodule

// File: rtl/dtlb_walker_chk.sv
module dtlb_walker_chk #(
  parameter int PA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            busy_o,
  input logic            resp_valid_o,
  input logic            resp_hit_o,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic [PA_W-1:0] mem_req_addr_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)); // R3
  AST_REQ_IN_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> busy_o); // R3
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !resp_valid_o); // R7
  AST_WALK_ENDS_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> resp_valid_o && !resp_hit_o); // R4
  AST_ACCEPT_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o |=> resp_valid_o || busy_o); // R2
  AST_HIT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_hit_o |-> $past(req_valid_i && !busy_o)); // R2
endmodule

bind dtlb_walker dtlb_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .busy_o          (busy_o),
  .resp_valid_o    (resp_valid_o),
  .resp_hit_o      (resp_hit_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o)
);

// File: tb/dtlb_walker_tb_top.sv
`timescale 1ns/1ps
module dtlb_walker_tb_top;
  localparam int VA_W = 32, PA_W = 32, PAGE_BYTES = 4096, ENTRIES = 8;
  localparam int PTE_BYTES = 4, PTE_W = 32, TID_W = 4;
  localparam int OFF_W = 12, PFN_W = PA_W - OFF_W, VPN_W = VA_W - OFF_W;
  localparam logic [PA_W-1:0] PT_BASE = 32'h8040_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             req_valid = 1'b0;
  logic [VA_W-1:0]  req_vaddr = '0;
  logic [TID_W-1:0] req_tid = '0;
  logic             mem_ready = 1'b0;
  logic             mem_rv = 1'b0;
  logic [PTE_W-1:0] mem_pte = '0;
  logic             busy, resp_valid, resp_hit, mem_req_valid;
  logic [PA_W-1:0]  resp_paddr, mem_req_addr;

  dtlb_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_tid_i(req_tid),
    .busy_o(busy), .resp_valid_o(resp_valid), .resp_hit_o(resp_hit),
    .resp_paddr_o(resp_paddr), .pt_base_i(PT_BASE),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_ready),
    .mem_req_addr_o(mem_req_addr), .mem_resp_valid_i(mem_rv),
    .mem_resp_pte_i(mem_pte)
  );

  int checks = 0, errors = 0;

  // reference model state
  int               m_st = 0;  // 0 idle, 1 request, 2 wait
  logic [VPN_W-1:0] m_vpn;
  logic [OFF_W-1:0] m_off;
  logic             exp_rv = 1'b0, exp_hit = 1'b0;
  logic [PA_W-1:0]  exp_pa = '0;
  logic [VPN_W-1:0] lru_v[$];   // front = most recent
  logic [PFN_W-1:0] lru_p[$];

  function automatic logic [PTE_W-1:0] pte_for(logic [VPN_W-1:0] v);
    logic [PFN_W-1:0] f;
    f = PFN_W'(v * 13 + 5);
    return {12'(v ^ 20'h00A5A), f};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [VPN_W-1:0] v;
    logic [PFN_W-1:0] f;
    int idx;
    exp_rv = 1'b0;
    case (m_st)
      0: if (req_valid) begin
        v = req_vaddr[VA_W-1:OFF_W];
        idx = -1;
        foreach (lru_v[i]) if (lru_v[i] == v) idx = i;
        if (idx >= 0) begin
          f = lru_p[idx];
          lru_v.delete(idx); lru_p.delete(idx);
          lru_v.push_front(v); lru_p.push_front(f);
          exp_rv = 1'b1; exp_hit = 1'b1;
          exp_pa = {f, req_vaddr[OFF_W-1:0]};
        end else begin
          m_st = 1; m_vpn = v; m_off = req_vaddr[OFF_W-1:0];
        end
      end
      1: if (mem_ready) m_st = 2;
      2: if (mem_rv) begin
        f = mem_pte[PFN_W-1:0];
        lru_v.push_front(m_vpn); lru_p.push_front(f);
        if (lru_v.size() > ENTRIES) begin
          void'(lru_v.pop_back()); void'(lru_p.pop_back());
        end
        exp_rv = 1'b1; exp_hit = 1'b0; exp_pa = {f, m_off};
        m_st = 0;
      end
      default: m_st = 0;
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; exp_rv = 1'b0; exp_hit = 1'b0; exp_pa = '0;
      lru_v.delete(); lru_p.delete();
    end else begin
      model_step();
    end
  end

  function automatic logic [VA_W-1:0] mk(int v, int off);
    return VA_W'((v << OFF_W) | (off & (PAGE_BYTES - 1)));
  endfunction

  logic [VA_W-1:0] pend[$];
  int n_dir;
  int issued = 0;
  int wait_cnt = 0;
  int cyc = 0;

  initial begin
    // directed: fill, hit with new offset and tag, evict LRU, probe
    for (int v = 1; v <= 8; v++) pend.push_back(mk(v, v * 16));
    pend.push_back(mk(1, 12'hFFF));  // R5 R8 hit, other offset/tag
    pend.push_back(mk(9, 12'h004));  // R6 evicts page 2
    pend.push_back(mk(1, 12'h000));  // R6 page 1 kept
    pend.push_back(mk(2, 12'h123));  // R6 page 2 now misses
    pend.push_back(mk(3, 12'h001));  // R6 page 3 evicted by page 2
    n_dir = pend.size();
    for (int k = 0; k < 700; k++)
      pend.push_back(mk(int'((32'($urandom_range(0, 11)) * 32'h0001_1113) & 32'hF_FFFF),
                        int'($urandom_range(0, 4095))));

    repeat (3) begin
      @(negedge clk);
      chk("R10", "busy in reset", 64'(busy), 64'd0);
      chk("R10", "resp_valid in reset", 64'(resp_valid), 64'd0);
      chk("R10", "mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
    end
    rst_n = 1'b1;

    while (pend.size() > 0 || m_st != 0 || exp_rv) begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        break;
      end
      chk("R3 R4 R7", "busy", 64'(busy), 64'(m_st != 0));
      chk("R3", "mem_req_valid", 64'(mem_req_valid), 64'(m_st == 1));
      if (m_st == 1)
        chk("R1 R3", "pte address", 64'(mem_req_addr),
            64'(PT_BASE + (PA_W'(m_vpn) * PTE_BYTES)));
      chk("R2 R4 R7 R9", "resp_valid", 64'(resp_valid), 64'(exp_rv));
      if (exp_rv) begin
        chk("R5 R6 R8", "resp_hit", 64'(resp_hit), 64'(exp_hit));
        chk("R1 R2 R4", "resp_paddr", 64'(resp_paddr), 64'(exp_pa));
      end

      // drive next inputs
      req_valid = 1'b0;
      req_vaddr = $urandom;
      req_tid   = TID_W'($urandom);  // R8 tag varies freely
      if (m_st == 0) begin
        if (pend.size() > 0 && (issued < n_dir || $urandom_range(0, 3) != 0)) begin
          req_valid = 1'b1;
          req_vaddr = pend.pop_front();
          issued++;
        end
      end else if ($urandom_range(0, 2) == 0) begin
        req_valid = 1'b1;  // R7 must be dropped
      end
      mem_ready = (issued <= n_dir) ? 1'b1 : ($urandom_range(0, 3) != 0);
      mem_rv  = 1'b0;
      mem_pte = $urandom;
      if (m_st == 2) begin
        if (wait_cnt == 0) begin
          mem_rv   = 1'b1;
          mem_pte  = pte_for(m_vpn);
          wait_cnt = $urandom_range(0, 3);
        end else begin
          wait_cnt--;
        end
      end else if (issued > n_dir && $urandom_range(0, 4) == 0) begin
        mem_rv = 1'b1;  // R9 stray response
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule